// File: doc/BRIEF.md
# State-Skipping Scan Pattern Generator

This block produces pseudorandom test patterns for a test-per-scan self-test scheme. A k-bit linear feedback shift register shifts right once per clock. Its least significant bit leaves the block serially as the scan-in stream. A modulo-m shift counter, where m is the scan chain length, marks the final shift of each pattern. That cycle is the pattern's end-state.

Only at an end-state may a combinational jump table override the register's natural successor. The table replaces it with the start state of a chosen next pattern. This skips patterns that add no fault coverage and replays the useful ones in an order that lowers switching energy. The jump table sees the register contents only on end-state cycles, so it stays still during ordinary shifts.

The jump pairs and the final end-state are fixed by parameters. A session begins on a start pulse. It ends when the final end-state is shifted out, and the done flag then holds until the next start.

Top module: `skip_tpg`

## Requirements
- R1: After reset, and before any start, scan_o, pat_done_o and sess_done_o are all 0.
- R2: Loading and shifting:
  - A cycle with start_i high loads SEED into the register and clears the shift counter. The next cycle is the first shift.
  - On every shift cycle, scan_o equals register bit 0. The register then shifts right.
  - The new bit 0 comes from bit 1. The new top bit is the XOR of the register bits whose TAP_MASK bit is 1.
- R3: pat_done_o is high for exactly one cycle per SCAN_LEN shift cycles. It is high on the cycle that shifts out the last bit of a pattern (counter value SCAN_LEN-1).
- R4: At an end-state that is not listed in JUMP_FROM, the register takes its natural successor.
- R5: At an end-state equal to JUMP_FROM[j], the next register value is JUMP_TO[j].
- R6: A register value equal to a JUMP_FROM entry has no effect on cycles other than end-states. Shifting then follows the natural sequence.
- R7: Session end:
  - When the end-state equals FINAL_STATE, sess_done_o rises on the next cycle and shifting stops.
  - While sess_done_o is high, scan_o and pat_done_o are 0.
- R8: sess_done_o stays high until start_i. A start from the done state replays the identical session from SEED.
- R9: A start during a running session abandons it and restarts from SEED with the counter cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Load seed and begin (or restart) a session |
| scan_o | output | 1 | Serial scan-in bit, the register LSB while running |
| pat_done_o | output | 1 | One-cycle strobe on the last shift of each pattern |
| sess_done_o | output | 1 | Session complete, held until the next start |

## Verification
The bench builds two instances.

The first instance uses the default 4-bit register with polynomial x^4+x^3+1, seed 9 and a 3-bit chain. Its patterns are 9-12-6, 11-5-10, 13-14-15, 7-3-1 and 8-4-2. The table skips the third pattern and swaps the last two: end-state 10 jumps to 8 and end-state 2 jumps to 7, and the session ends at end-state 1. This brings a natural transition, two jumps, the finish, the hold and both restart paths within reach.

The second instance uses seed 1 and a 4-bit chain. Its table holds an entry for state 8, which occurs only in mid-pattern, next to a real jump from end-state 2 to 5. This exposes an override that is wrongly taken on ordinary shift cycles.

// File: rtl/skip_tpg_pkg.sv
package skip_tpg_pkg;
  typedef enum logic [1:0] {
    TPG_IDLE = 2'd0,
    TPG_RUN  = 2'd1,
    TPG_DONE = 2'd2
  } tpg_mode_e;
endpackage

// File: rtl/tpg_lfsr.sv
module tpg_lfsr #(
  parameter int unsigned         W        = 4,
  parameter logic [W-1:0]        TAP_MASK = 4'b0011,
  parameter logic [W-1:0]        SEED     = 4'd9
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         adv_i,
  input  logic         jump_i,
  input  logic [W-1:0] jump_tgt_i,
  output logic [W-1:0] state_o
);
  logic [W-1:0] state_q;
  logic [W-1:0] natural_w;
  logic [W-1:0] next_w;

  assign natural_w = {^(state_q & TAP_MASK), state_q[W-1:1]};

  // per-bit 2:1 override mux
  for (genvar i = 0; i < int'(W); i++) begin : g_mux
    assign next_w[i] = jump_i ? jump_tgt_i[i] : natural_w[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     state_q <= SEED;
    else if (load_i) state_q <= SEED;
    else if (adv_i)  state_q <= next_w;
  end

  assign state_o = state_q;
endmodule

// File: rtl/tpg_shift_cnt.sv
module tpg_shift_cnt #(
  parameter int unsigned LEN = 3,
  localparam int unsigned CW = (LEN > 1) ? $clog2(LEN) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic last_o
);
  logic [CW-1:0] cnt_q;

  assign last_o = (cnt_q == CW'(LEN - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (en_i)   cnt_q <= last_o ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/tpg_map_logic.sv
module tpg_map_logic #(
  parameter int unsigned                 W           = 4,
  parameter int unsigned                 NJ          = 2,
  parameter logic [NJ-1:0][W-1:0]        JUMP_FROM   = {4'd2, 4'd10},
  parameter logic [NJ-1:0][W-1:0]        JUMP_TO     = {4'd7, 4'd8},
  parameter logic [W-1:0]                FINAL_STATE = 4'd1
) (
  input  logic         en_i,
  input  logic [W-1:0] state_i,
  output logic         ctrl_o,
  output logic [W-1:0] tgt_o,
  output logic         final_o
);
  logic [W-1:0]  seen_w;
  logic [NJ-1:0] hit_w;

  // inputs held at zero except on end-state cycles
  assign seen_w = state_i & {W{en_i}};

  for (genvar j = 0; j < int'(NJ); j++) begin : g_hit
    assign hit_w[j] = en_i && (seen_w == JUMP_FROM[j]);
  end

  always_comb begin
    tgt_o = '0;
    for (int j = 0; j < int'(NJ); j++) tgt_o |= JUMP_TO[j] & {W{hit_w[j]}};
  end

  assign ctrl_o  = |hit_w;
  assign final_o = en_i && (seen_w == FINAL_STATE);
endmodule

// File: rtl/skip_tpg.sv
module skip_tpg
  import skip_tpg_pkg::*;
#(
  parameter int unsigned                        LFSR_W      = 4,
  parameter int unsigned                        SCAN_LEN    = 3,
  parameter logic [LFSR_W-1:0]                  TAP_MASK    = 4'b0011,
  parameter logic [LFSR_W-1:0]                  SEED        = 4'd9,
  parameter int unsigned                        NUM_JUMPS   = 2,
  parameter logic [NUM_JUMPS-1:0][LFSR_W-1:0]   JUMP_FROM   = {4'd2, 4'd10},
  parameter logic [NUM_JUMPS-1:0][LFSR_W-1:0]   JUMP_TO     = {4'd7, 4'd8},
  parameter logic [LFSR_W-1:0]                  FINAL_STATE = 4'd1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic scan_o,
  output logic pat_done_o,
  output logic sess_done_o
);
  tpg_mode_e         mode_q;
  logic [LFSR_W-1:0] lfsr_q;
  logic [LFSR_W-1:0] ml_tgt;
  logic              ml_ctrl, ml_final;
  logic              cnt_last, run_w, m_en, finish_w, adv_w;

  assign run_w    = (mode_q == TPG_RUN);
  assign m_en     = run_w && cnt_last;
  assign finish_w = m_en && ml_final && !start_i;
  assign adv_w    = run_w && !start_i && !finish_w;

  tpg_shift_cnt #(.LEN(SCAN_LEN)) i_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (start_i),
    .en_i   (adv_w),
    .last_o (cnt_last)
  );

  tpg_map_logic #(
    .W(LFSR_W), .NJ(NUM_JUMPS), .JUMP_FROM(JUMP_FROM),
    .JUMP_TO(JUMP_TO), .FINAL_STATE(FINAL_STATE)
  ) i_map (
    .en_i    (m_en),
    .state_i (lfsr_q),
    .ctrl_o  (ml_ctrl),
    .tgt_o   (ml_tgt),
    .final_o (ml_final)
  );

  tpg_lfsr #(.W(LFSR_W), .TAP_MASK(TAP_MASK), .SEED(SEED)) i_lfsr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (start_i),
    .adv_i      (adv_w),
    .jump_i     (ml_ctrl && m_en),
    .jump_tgt_i (ml_tgt),
    .state_o    (lfsr_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       mode_q <= TPG_IDLE;
    else if (start_i)  mode_q <= TPG_RUN;
    else if (finish_w) mode_q <= TPG_DONE;
  end

  assign scan_o      = run_w && lfsr_q[0];
  assign pat_done_o  = m_en;
  assign sess_done_o = (mode_q == TPG_DONE);
endmodule

// File: rtl/skip_tpg_chk.sv
module skip_tpg_chk #(
  parameter int unsigned                        LFSR_W      = 4,
  parameter int unsigned                        SCAN_LEN    = 3,
  parameter logic [LFSR_W-1:0]                  TAP_MASK    = 4'b0011,
  parameter logic [LFSR_W-1:0]                  SEED        = 4'd9,
  parameter int unsigned                        NUM_JUMPS   = 2,
  parameter logic [NUM_JUMPS-1:0][LFSR_W-1:0]   JUMP_FROM   = {4'd2, 4'd10},
  parameter logic [NUM_JUMPS-1:0][LFSR_W-1:0]   JUMP_TO     = {4'd7, 4'd8},
  parameter logic [LFSR_W-1:0]                  FINAL_STATE = 4'd1,
  localparam int unsigned GW = $clog2(SCAN_LEN + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              run_i,
  input logic              scan_o,
  input logic              pat_done_o,
  input logic              sess_done_o,
  input logic [LFSR_W-1:0] lfsr_state
);
  logic [GW-1:0]     gap_q;
  logic [LFSR_W-1:0] natural_w;
  logic              in_table_w;

  assign natural_w = {^(lfsr_state & TAP_MASK), lfsr_state[LFSR_W-1:1]};

  always_comb begin
    in_table_w = 1'b0;
    for (int j = 0; j < int'(NUM_JUMPS); j++)
      if (lfsr_state == JUMP_FROM[j]) in_table_w = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      gap_q <= '0;
    else if (start_i) gap_q <= '0;
    else if (run_i)   gap_q <= pat_done_o ? '0 : gap_q + 1'b1;
  end

  AST_START_SEED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> lfsr_state == SEED); // R2
  AST_STROBE_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pat_done_o |-> gap_q == GW'(SCAN_LEN - 1)); // R3
  AST_STROBE_DUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && gap_q == GW'(SCAN_LEN - 1) |-> pat_done_o); // R3
  AST_NO_END_JUMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pat_done_o && !start_i && !in_table_w && lfsr_state != FINAL_STATE
    |=> lfsr_state == $past(natural_w)); // R4
  AST_MID_NATURAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && !pat_done_o && !start_i |=> lfsr_state == $past(natural_w)); // R6

  for (genvar j = 0; j < int'(NUM_JUMPS); j++) begin : g_jump
    AST_JUMP_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pat_done_o && !start_i && lfsr_state == JUMP_FROM[j] && lfsr_state != FINAL_STATE
      |=> lfsr_state == JUMP_TO[j]); // R5
  end

  AST_FINAL_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pat_done_o && !start_i && lfsr_state == FINAL_STATE |=> sess_done_o); // R7
  AST_DONE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sess_done_o |-> !scan_o && !pat_done_o); // R7
  AST_DONE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sess_done_o && !start_i |=> sess_done_o); // R8
  AST_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> run_i && !sess_done_o); // R9
endmodule

bind skip_tpg skip_tpg_chk #(
  .LFSR_W(LFSR_W), .SCAN_LEN(SCAN_LEN), .TAP_MASK(TAP_MASK), .SEED(SEED),
  .NUM_JUMPS(NUM_JUMPS), .JUMP_FROM(JUMP_FROM), .JUMP_TO(JUMP_TO),
  .FINAL_STATE(FINAL_STATE)
) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .run_i       (run_w),
  .scan_o      (scan_o),
  .pat_done_o  (pat_done_o),
  .sess_done_o (sess_done_o),
  .lfsr_state  (lfsr_q)
);

// File: tb/test_skip_tpg.sv
module test_skip_tpg;
  localparam time CLK_PERIOD = 10ns;

  // second build: chain of 4, mid-pattern table entry 8, real jump 2->5, end at 14
  localparam int unsigned         M_B     = 4;
  localparam logic [3:0]          TAP_B   = 4'b0011;
  localparam logic [3:0]          SEED_B  = 4'd1;
  localparam logic [1:0][3:0]     FROM_B  = {4'd2, 4'd8};
  localparam logic [1:0][3:0]     TO_B    = {4'd5, 4'd3};
  localparam logic [3:0]          FIN_B   = 4'd14;

  // {scan, pat_done, sess_done} per cycle for the default build
  localparam logic [2:0] VEC_A [13] = '{
    3'b100, 3'b000, 3'b010,   // 9 12 6   end 6 natural
    3'b100, 3'b100, 3'b010,   // 11 5 10  end 10 -> 8
    3'b000, 3'b000, 3'b010,   // 8 4 2    end 2 -> 7
    3'b100, 3'b100, 3'b110,   // 7 3 1    final
    3'b001
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_a = 1'b0, start_b = 1'b0;
  logic scan_a, pd_a, sd_a, scan_b, pd_b, sd_b;
  int   n_checks = 0;
  int   n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  skip_tpg i_skip_tpg (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_a),
    .scan_o(scan_a), .pat_done_o(pd_a), .sess_done_o(sd_a)
  );

  skip_tpg #(
    .LFSR_W(4), .SCAN_LEN(M_B), .TAP_MASK(TAP_B), .SEED(SEED_B),
    .NUM_JUMPS(2), .JUMP_FROM(FROM_B), .JUMP_TO(TO_B), .FINAL_STATE(FIN_B)
  ) i_skip_tpg_b (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_b),
    .scan_o(scan_b), .pat_done_o(pd_b), .sess_done_o(sd_b)
  );

  task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {scan,pat,done} actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic pulse_a();
    @(negedge clk) start_a = 1'b1;
    @(negedge clk) start_a = 1'b0;
  endtask

  task automatic walk_a(input string req);
    for (int i = 0; i < 13; i++) begin
      chk(req, {scan_a, pd_a, sd_a}, VEC_A[i]);
      @(negedge clk);
    end
  endtask

  function automatic logic [3:0] nat_b(input logic [3:0] s);
    return {^(s & TAP_B), s[3:1]};
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [2:0] exp_b [17];
    int         len_b;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 reset A", {scan_a, pd_a, sd_a}, 3'b000);
    chk("R1 reset B", {scan_b, pd_b, sd_b}, 3'b000);

    // table walk: R2 R3 R4 R5 R7
    pulse_a();
    walk_a("R2/R3/R4/R5/R7 session A");

    // done holds, outputs quiet
    for (int i = 0; i < 5; i++) begin
      chk("R7/R8 done hold", {scan_a, pd_a, sd_a}, 3'b001);
      @(negedge clk);
    end

    // restart from done replays the session
    pulse_a();
    walk_a("R8 replay");

    // restart mid-session
    pulse_a();
    repeat (4) @(negedge clk);
    chk("R9 mid session before restart", {scan_a, pd_a, sd_a}, 3'b100);
    pulse_a();
    walk_a("R9 restart");

    // second build, expected stream from a software model
    begin
      logic [3:0] s;
      int unsigned c;
      bit fin;
      s = SEED_B; c = 0; len_b = 0; fin = 0;
      while (!fin && len_b < 16) begin
        logic strobe;
        strobe = (c == M_B - 1);
        exp_b[len_b] = {s[0], strobe, 1'b0};
        len_b++;
        if (strobe) begin
          if (s == FIN_B) fin = 1;
          else begin
            logic [3:0] nx;
            nx = nat_b(s);
            for (int j = 0; j < 2; j++) if (s == FROM_B[j]) nx = TO_B[j];
            s = nx;
          end
          c = 0;
        end else begin
          s = nat_b(s);
          c++;
        end
      end
      exp_b[len_b] = 3'b001;
    end
    chk("R5/R6 model length", {1'b0, len_b == 8, 1'b0}, 3'b010);
    @(negedge clk) start_b = 1'b1;
    @(negedge clk) start_b = 1'b0;
    for (int i = 0; i <= len_b; i++) begin
      chk("R6 mid-pattern entry ignored, B", {scan_b, pd_b, sd_b}, exp_b[i]);
      @(negedge clk);
    end
    chk("R7 B done quiet", {scan_b, pd_b, sd_b}, 3'b001);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule